// File: doc/BRIEF.md
# Multi-mode hex sequence counter

A 4-bit counter whose counting sequence is picked by a 3-bit mode input, with a built-in hexadecimal seven-segment decoder driving seven separate active-high segment outputs. Each mode fixes a first value, a last value, a direction and a stride of one or two. When the count reaches the last value, it reloads the first value, so each mode loops over its own short sequence. One mode simply holds the display at 5.

The block takes one step on every rising edge of a slow system clock. Any division from a faster oscillator is done outside the block. An active-low asynchronous clear forces the count to zero at once. The first clock edge after the clear is released loads the first value of the active mode. A mode change loads the new mode's first value on the next edge.

Top module: `hex_seq_counter`

## Requirements
- R1: While rst_ni is low the count is 0 and the segments show digit 0 (pattern 0x3F), with no clock edge needed. The first rising edge after release loads the first value of the active mode.
- R2: Mode 3'b000 holds the count at 5 from the first edge on.
- R3: Mode 3'b001 counts 1,2,...,9 and then wraps to 1.
- R4: Mode 3'b010 counts odd values upward 3,5,7,9,B and then wraps to 3.
- R5: Mode 3'b011 counts even values upward 2,4,6,8,A,C,E and then wraps to 2.
- R6: Mode 3'b100 counts downward by one from F to 3 and then wraps to F.
- R7: Mode 3'b101 counts odd values downward 9,7,5,3,1 and then wraps to 9.
- R8: Mode 3'b110 counts even values downward C,A,8,6,4,2,0 and then wraps to C.
- R9: Mode 3'b111 decrements by one through every value F..0 and wraps from 0 to F.
- R10: On the first edge with a mode different from the one seen on the previous edge, and on the first edge after clear release, the count loads the first value of the mode now applied.
- R11: Segments are active-high with seg0_o=a through seg6_o=g. The bit vector {g,f,e,d,c,b,a} for digits 0..F is 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 (hex), which gives the forms A, b, C, d, E, F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow step clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous clear |
| mode_i | input | 3 | Sequence select |
| seg0_o | output | 1 | Segment a |
| seg1_o | output | 1 | Segment b |
| seg2_o | output | 1 | Segment c |
| seg3_o | output | 1 | Segment d |
| seg4_o | output | 1 | Segment e |
| seg5_o | output | 1 | Segment f |
| seg6_o | output | 1 | Segment g |

## Verification
A mode applied before a rising edge shows its effect on the segments right after that edge, because only one register sits between the mode input and the decoder. Clear shows its effect at once, with no edge needed. The bench changes the mode on the falling edge and compares all seven segments on the next falling edge, against a count it predicts one step ahead. Clear checks sample one time unit after rst_ni falls, and again before the first edge after release. The sweep covers every ordered pair of modes, so every restart and every wrap is compared in the cycle it occurs.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  localparam int CNT_W  = 4;
  localparam int MODE_W = 3;
  localparam int SEG_W  = 7;
  localparam int DIGITS = 1 << CNT_W;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [SEG_W-1:0]  seg_t;

  typedef struct packed {
    cnt_t first;
    cnt_t last;
    logic down;
    logic stride2;
    logic hold;
  } seq_cfg_t;
endpackage

// File: rtl/hsc_mode_rom.sv
module hsc_mode_rom
  import hsc_pkg::*;
(
  input  mode_t    mode_i,
  output seq_cfg_t cfg_o
);
  always_comb begin
    unique case (mode_i)
      3'd0:    cfg_o = '{first: cnt_t'(4'h5), last: cnt_t'(4'h5), down: 1'b0, stride2: 1'b0, hold: 1'b1};
      3'd1:    cfg_o = '{first: cnt_t'(4'h1), last: cnt_t'(4'h9), down: 1'b0, stride2: 1'b0, hold: 1'b0};
      3'd2:    cfg_o = '{first: cnt_t'(4'h3), last: cnt_t'(4'hB), down: 1'b0, stride2: 1'b1, hold: 1'b0};
      3'd3:    cfg_o = '{first: cnt_t'(4'h2), last: cnt_t'(4'hE), down: 1'b0, stride2: 1'b1, hold: 1'b0};
      3'd4:    cfg_o = '{first: cnt_t'(4'hF), last: cnt_t'(4'h3), down: 1'b1, stride2: 1'b0, hold: 1'b0};
      3'd5:    cfg_o = '{first: cnt_t'(4'h9), last: cnt_t'(4'h1), down: 1'b1, stride2: 1'b1, hold: 1'b0};
      3'd6:    cfg_o = '{first: cnt_t'(4'hC), last: cnt_t'(4'h0), down: 1'b1, stride2: 1'b1, hold: 1'b0};
      default: cfg_o = '{first: cnt_t'(4'hF), last: cnt_t'(4'h0), down: 1'b1, stride2: 1'b0, hold: 1'b0};
    endcase
  end
endmodule

// File: rtl/hsc_step_logic.sv
module hsc_step_logic
  import hsc_pkg::*;
(
  input  seq_cfg_t cfg_i,
  input  cnt_t     cur_i,
  input  logic     restart_i,
  output cnt_t     nxt_o,
  output logic     in_seq_o
);
  localparam cnt_t STEP_ONE = cnt_t'(1);
  localparam cnt_t STEP_TWO = cnt_t'(2);

  cnt_t lo, hi, stride;

  always_comb begin
    lo       = cfg_i.down ? cfg_i.last  : cfg_i.first;
    hi       = cfg_i.down ? cfg_i.first : cfg_i.last;
    stride   = cfg_i.stride2 ? STEP_TWO : STEP_ONE;
    // parity must match the first value when striding by two
    in_seq_o = (cur_i >= lo) && (cur_i <= hi) &&
               (!cfg_i.stride2 || (cur_i[0] == cfg_i.first[0]));
    if (restart_i || !in_seq_o || (cur_i == cfg_i.last))
      nxt_o = cfg_i.first;
    else if (cfg_i.hold)
      nxt_o = cur_i;
    else if (cfg_i.down)
      nxt_o = cur_i - stride;
    else
      nxt_o = cur_i + stride;
  end
endmodule

// File: rtl/hsc_seg_decode.sv
module hsc_seg_decode
  import hsc_pkg::*;
(
  input  cnt_t digit_i,
  output seg_t seg_o
);
  // bit 0 = a ... bit 6 = g, active-high
  always_comb begin
    unique case (digit_i)
      4'h0:    seg_o = 7'h3F;
      4'h1:    seg_o = 7'h06;
      4'h2:    seg_o = 7'h5B;
      4'h3:    seg_o = 7'h4F;
      4'h4:    seg_o = 7'h66;
      4'h5:    seg_o = 7'h6D;
      4'h6:    seg_o = 7'h7D;
      4'h7:    seg_o = 7'h07;
      4'h8:    seg_o = 7'h7F;
      4'h9:    seg_o = 7'h6F;
      4'hA:    seg_o = 7'h77;
      4'hB:    seg_o = 7'h7C;
      4'hC:    seg_o = 7'h39;
      4'hD:    seg_o = 7'h5E;
      4'hE:    seg_o = 7'h79;
      default: seg_o = 7'h71;
    endcase
  end

  // R11
  always_comb begin
    if (digit_i == 4'h1) one_two_seg_chk: assert ($countones(seg_o) == 2);
  end
endmodule

// File: rtl/hex_seq_counter.sv
module hex_seq_counter
  import hsc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  output logic              seg0_o,
  output logic              seg1_o,
  output logic              seg2_o,
  output logic              seg3_o,
  output logic              seg4_o,
  output logic              seg5_o,
  output logic              seg6_o
);
  cnt_t     count_q, count_d;
  mode_t    mode_q;
  logic     valid_q;
  logic     restart_w, in_seq_w;
  seq_cfg_t cfg_w;
  seg_t     seg_w;

  assign restart_w = !valid_q || (mode_i != mode_q);

  hsc_mode_rom u_rom (
    .mode_i (mode_i),
    .cfg_o  (cfg_w)
  );

  hsc_step_logic u_step (
    .cfg_i     (cfg_w),
    .cur_i     (count_q),
    .restart_i (restart_w),
    .nxt_o     (count_d),
    .in_seq_o  (in_seq_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      mode_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      count_q <= count_d;
      mode_q  <= mode_i;
      valid_q <= 1'b1;
    end
  end

  hsc_seg_decode u_dec (
    .digit_i (count_q),
    .seg_o   (seg_w)
  );

  assign seg0_o = seg_w[0];
  assign seg1_o = seg_w[1];
  assign seg2_o = seg_w[2];
  assign seg3_o = seg_w[3];
  assign seg4_o = seg_w[4];
  assign seg5_o = seg_w[5];
  assign seg6_o = seg_w[6];

  // R1
  clr_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> (count_q == '0));

  // R2
  hold_five_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0) |=> (count_q == cnt_t'(5)));

  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && (mode_i == mode_q) && (count_q == cfg_w.last)) |=> (count_q == $past(cfg_w.first)));

  // R9
  dec_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && (mode_q == 3'd7) && (mode_i == 3'd7) && (count_q != '0)) |=> (count_q == $past(count_q) - cnt_t'(1)));

  // R10
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_w |=> (count_q == $past(cfg_w.first)));

  // R10
  seq_member_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && (mode_i == mode_q)) |-> in_seq_w);

  // R11
  eight_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_q == cnt_t'(8)) |-> (seg_w == 7'h7F));
endmodule

// File: tb/tb_hex_seq_counter.sv
module tb_hex_seq_counter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic [2:0] mode = 3'd0;
  logic       s0, s1, s2, s3, s4, s5, s6;
  logic [6:0] segs;

  int n_cmp = 0;
  int n_bad = 0;
  int ref_cnt = 0;
  int ref_mode = 0;
  bit ref_valid = 1'b0;

  hex_seq_counter dut (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .seg0_o (s0), .seg1_o (s1), .seg2_o (s2), .seg3_o (s3),
    .seg4_o (s4), .seg5_o (s5), .seg6_o (s6)
  );

  assign segs = {s6, s5, s4, s3, s2, s1, s0};

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int first_of(int m);
    case (m)
      0: return 5;  1: return 1;  2: return 3;  3: return 2;
      4: return 15; 5: return 9;  6: return 12; default: return 15;
    endcase
  endfunction

  function automatic int last_of(int m);
    case (m)
      0: return 5;  1: return 9;  2: return 11; 3: return 14;
      4: return 3;  5: return 1;  6: return 0;  default: return 0;
    endcase
  endfunction

  function automatic int delta_of(int m);
    case (m)
      0: return 0;  1: return 1;  2: return 2;  3: return 2;
      4: return -1; 5: return -2; 6: return -2; default: return -1;
    endcase
  endfunction

  function automatic bit member(int m, int v);
    int lo = (first_of(m) < last_of(m)) ? first_of(m) : last_of(m);
    int hi = (first_of(m) < last_of(m)) ? last_of(m) : first_of(m);
    if (v < lo || v > hi) return 1'b0;
    if (delta_of(m) == 2 || delta_of(m) == -2) return (v % 2) == (first_of(m) % 2);
    return 1'b1;
  endfunction

  function automatic logic [6:0] seg_of(int d);
    case (d)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;  10: return 7'h77; 11: return 7'h7C;
      12: return 7'h39; 13: return 7'h5E; 14: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  function automatic string tag_of(int m);
    case (m)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R6"; 5: return "R7"; 6: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic check(string tag, logic [6:0] exp);
    n_cmp++;
    if (segs !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t mode=%0d actual=%h expected=%h", tag, $time, mode, segs, exp);
    end
  endtask

  // called at a falling edge: apply mode, predict, check at next falling edge
  task automatic step(int m);
    int    nxt;
    string tag;
    mode = 3'(m);
    if (!ref_valid || m != ref_mode || !member(m, ref_cnt)) begin
      nxt = first_of(m);
      tag = "R10";
    end else if (ref_cnt == last_of(m)) begin
      nxt = first_of(m);
      tag = tag_of(m);
    end else begin
      nxt = ref_cnt + delta_of(m);
      tag = tag_of(m);
    end
    @(posedge clk);
    ref_cnt   = nxt;
    ref_valid = 1'b1;
    ref_mode  = m;
    @(negedge clk);
    check({tag, "/R11"}, seg_of(ref_cnt));
  endtask

  // R1: clear mid-cycle, observed before any edge
  task automatic pulse_clear();
    #1 rst_ni = 1'b0;
    #1 check("R1", 7'h3F);
    @(negedge clk);
    check("R1", 7'h3F);
    rst_ni    = 1'b1;
    ref_valid = 1'b0;
    ref_cnt   = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int plan [12] = '{0, 2, 1, 3, 2, 3, 4, 5, 6, 1, 5, 7};
    #1 rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1", 7'h3F);
    rst_ni = 1'b1;

    // mixed run through all modes
    foreach (plan[i]) for (int k = 0; k < 20; k++) step(plan[i]);

    // every ordered mode pair, long enough to wrap the longest sequence
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        for (int k = 0; k < 3; k++) step(a);
        for (int k = 0; k < 20; k++) step(b);
      end

    // clear in every mode, then restart from the mode's first value
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 4; k++) step(m);
      pulse_clear();
      for (int k = 0; k < 4; k++) step(m);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule